// File: doc/BRIEF.md
# Pulse-Swallow Dual-Modulus Divider

This block divides a high-rate oscillator-side clock down to a comparison pulse for a phase comparator. It steers a two-modulus prescaler through a modulus-control line. For the first A prescaler cycles of every output period the prescaler divides by P+1. For the remaining cycles it divides by P. A main counter ends the period after N prescaler cycles in total. The overall ratio is therefore P×N+A, and the ratio can be set in single-cycle steps even though the prescaler itself only offers two coarse ratios.

The prescaler is modelled inside the block as a synthesizable counter on the same clock, so every count is in cycles of `clk`, which stands for the oscillator input. The swallow value, the main value and the modulus-select bit are plain control inputs held by a register stage outside the block. They are sampled only at period boundaries, so the block has no streaming interface and no handshake. A sticky flag reports settings that break the rules of the ratio formula. Even then the divider still produces a defined period.

Top module: `pswallow_div`

## Requirements
- R1: With 5 ≤ N and A < N, consecutive `fp_pulse` assertions are exactly P×N+A cycles of `clk` apart.
- R2: `mod_sel` = 1 selects the low base ratio P = 64 (prescaler 64/65). `mod_sel` = 0 selects the high base ratio P = 128 (prescaler 128/129).
- R3: `fp_pulse` is high for exactly one `clk` cycle per output period.
- R4: `mod_ctl` is 1 while the prescaler divides by P+1 and 0 while it divides by P. In each period it is high for exactly A×(P+1) cycles, forming one run that starts with the period, and it never rises when A = 0.
- R5: `swallow_a` is 7 bits wide (0 to 127) and `main_n` is 11 bits wide (up to 2047). The full swallow value A = 127 is honoured.
- R6: `swallow_a`, `main_n` and `mod_sel` are sampled only in the cycle that ends a period. A change made inside a period leaves that period's length unchanged and governs the next one.
- R7: `cfg_err` becomes 1 once a period starts with N < 5 or with A ≥ N. It stays 1 regardless of later settings until reset.
- R8: With an illegal setting the period is P×M + min(A, M) cycles, where M = max(N, 1).
- R9: While `rst_n` is low, `fp_pulse`, `mod_ctl` and `cfg_err` are 0. The first period starts in the first cycle after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator-side clock; every count is in its cycles |
| rst_n | input | 1 | Asynchronous active-low reset |
| swallow_a | input | 7 | Swallow value A, held stable by the register stage outside the block |
| main_n | input | 11 | Main counter value N |
| mod_sel | input | 1 | 1: P = 64, 0: P = 128 |
| mod_ctl | output | 1 | Modulus control to the prescaler, 1 = divide by P+1 |
| fp_pulse | output | 1 | One-cycle comparison pulse, once per period |
| cfg_err | output | 1 | Sticky flag for an illegal N or for A ≥ N |

## Verification
The checker watches several properties on every cycle:
- the comparison pulse is a single cycle wide and always follows a prescaler terminal count;
- the modulus control falls only at a prescaler cycle boundary;
- each period opens with the modulus control matching whether the sampled A was non-zero;
- the error flag is set at any period that began with a bad setting, and never clears.

Some properties can only be shown by the directed scenarios, which count cycles at the ports:
- the exact period lengths P×N+A and the fallback length for illegal settings;
- the total time spent at P+1;
- the full swallow value of 127;
- the deferred effect of a change made mid-period.

// File: rtl/pswd_pkg.sv
package pswd_pkg;

  typedef enum logic {
    MODC_BASE    = 1'b0,
    MODC_SWALLOW = 1'b1
  } modc_e;

  // Base prescaler ratio selected by the modulus-select bit.
  function automatic int unsigned base_ratio(input logic sel,
                                             input int unsigned lo,
                                             input int unsigned hi);
    return sel ? lo : hi;
  endfunction

endpackage

// File: rtl/pswd_prescaler.sv
// Two-modulus prescaler model: counts a cycle of len_m1+1 clocks and
// flags its final clock with pulse.
module pswd_prescaler #(
  parameter int unsigned PC_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            reload,
  input  logic [PC_W-1:0] len_m1,
  output logic            pulse
);

  logic [PC_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (reload) begin
      cnt_q <= len_m1;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign pulse = (cnt_q == '0);

endmodule

// File: rtl/pswd_swallow.sv
// Swallow counter: counts prescaler cycles still to run at P+1.
module pswd_swallow #(
  parameter int unsigned SW_W = 7
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic [SW_W-1:0] load_val,
  input  logic            step,
  output logic            nz_next
);

  logic [SW_W-1:0] cnt_q;
  logic [SW_W-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load) begin
      cnt_d = load_val;
    end else if (step && (cnt_q != '0)) begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign nz_next = (cnt_d != '0);

endmodule

// File: rtl/pswd_main.sv
// Main counter: counts prescaler cycles left in the output period.
// A load of 0 or 1 both mean a single prescaler cycle.
module pswd_main #(
  parameter int unsigned MN_W = 11
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic [MN_W-1:0] load_val,
  input  logic            step,
  output logic            last
);

  logic [MN_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (step) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign last = (cnt_q[MN_W-1:1] == '0);

endmodule

// File: rtl/pswallow_div.sv
module pswallow_div #(
  parameter int unsigned SW_W  = 7,
  parameter int unsigned MN_W  = 11,
  parameter int unsigned P_LO  = 64,
  parameter int unsigned P_HI  = 128,
  parameter int unsigned N_MIN = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [SW_W-1:0] swallow_a,
  input  logic [MN_W-1:0] main_n,
  input  logic            mod_sel,
  output logic            mod_ctl,
  output logic            fp_pulse,
  output logic            cfg_err
);
  import pswd_pkg::*;

  localparam int unsigned PC_W = $clog2(P_HI + 1);
  localparam logic [PC_W-1:0] LO_R = PC_W'(P_LO);
  localparam logic [PC_W-1:0] HI_R = PC_W'(P_HI);
  localparam logic [MN_W-1:0] NMIN_V = MN_W'(N_MIN);

  logic            primed_q;
  logic            pmode_q;
  modc_e           modc_q;
  logic            fp_q;
  logic            err_q;

  logic            pre_pulse;
  logic            last;
  logic            sw_nz_next;
  logic            boundary;
  logic            step;
  logic            reload;
  logic [PC_W-1:0] base_nxt;
  logic [PC_W-1:0] len_m1;
  logic            bad_cfg;

  assign boundary = !primed_q || (pre_pulse && last);
  assign step     = primed_q && pre_pulse && !last;
  assign reload   = boundary || pre_pulse;

  always_comb begin
    if (boundary) base_nxt = PC_W'(base_ratio(mod_sel, P_LO, P_HI));
    else          base_nxt = pmode_q ? LO_R : HI_R;
    len_m1 = sw_nz_next ? base_nxt : base_nxt - 1'b1;
  end

  assign bad_cfg = (main_n < NMIN_V) || ({{(MN_W-SW_W){1'b0}}, swallow_a} >= main_n);

  pswd_prescaler #(.PC_W(PC_W)) u_pre (
    .clk    (clk),
    .rst_n  (rst_n),
    .reload (reload),
    .len_m1 (len_m1),
    .pulse  (pre_pulse)
  );

  pswd_swallow #(.SW_W(SW_W)) u_swl (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (boundary),
    .load_val (swallow_a),
    .step     (step),
    .nz_next  (sw_nz_next)
  );

  pswd_main #(.MN_W(MN_W)) u_main (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (boundary),
    .load_val (main_n),
    .step     (step),
    .last     (last)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      primed_q <= 1'b0;
      pmode_q  <= 1'b0;
      modc_q   <= MODC_BASE;
      fp_q     <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      primed_q <= 1'b1;
      fp_q     <= primed_q && pre_pulse && last;
      if (boundary) begin
        pmode_q <= mod_sel;
        if (bad_cfg) err_q <= 1'b1;
      end
      if (reload) modc_q <= sw_nz_next ? MODC_SWALLOW : MODC_BASE;
    end
  end

  assign mod_ctl  = (modc_q == MODC_SWALLOW);
  assign fp_pulse = fp_q;
  assign cfg_err  = err_q;

endmodule

// File: rtl/pswd_chk.sv
module pswd_chk #(
  parameter int unsigned SW_W  = 7,
  parameter int unsigned MN_W  = 11,
  parameter int unsigned N_MIN = 5
) (
  input logic            clk,
  input logic            rst_n,
  input logic [SW_W-1:0] swallow_a,
  input logic [MN_W-1:0] main_n,
  input logic            mod_ctl,
  input logic            fp_pulse,
  input logic            cfg_err,
  input logic            pre_pulse
);

  // R3: pulse one cycle wide
  p_fp_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    fp_pulse |=> !fp_pulse);

  // R3: pulse only after a prescaler terminal count
  p_fp_after_pre_r3: assert property (@(posedge clk) disable iff (!rst_n)
    fp_pulse |-> $past(pre_pulse));

  // R4: modulus control drops only at a prescaler cycle boundary
  p_modc_fall_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mod_ctl) |-> $past(pre_pulse));

  // R4: a period opens at P+1 exactly when the sampled A is non-zero
  p_modc_start_r4: assert property (@(posedge clk) disable iff (!rst_n)
    fp_pulse |-> (mod_ctl == ($past(swallow_a) != '0)));

  // R7: flag raised for a period started with a bad setting
  p_err_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (fp_pulse && (($past(main_n) < MN_W'(N_MIN)) ||
                  ({{(MN_W-SW_W){1'b0}}, $past(swallow_a)} >= $past(main_n))))
    |-> cfg_err);

  // R7: flag is sticky
  p_err_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |=> cfg_err);

endmodule

bind pswallow_div pswd_chk #(.SW_W(SW_W), .MN_W(MN_W), .N_MIN(N_MIN)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .swallow_a (swallow_a),
  .main_n    (main_n),
  .mod_ctl   (mod_ctl),
  .fp_pulse  (fp_pulse),
  .cfg_err   (cfg_err),
  .pre_pulse (pre_pulse)
);

// File: tb/pswallow_div_tb.sv
`timescale 1ns/1ps
module pswallow_div_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [6:0]  swallow_a = '0;
  logic [10:0] main_n = 11'd10;
  logic        mod_sel = 1'b1;
  logic        mod_ctl;
  logic        fp_pulse;
  logic        cfg_err;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  pswallow_div dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .swallow_a (swallow_a),
    .main_n    (main_n),
    .mod_sel   (mod_sel),
    .mod_ctl   (mod_ctl),
    .fp_pulse  (fp_pulse),
    .cfg_err   (cfg_err)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int exp_period(input int a, input int n, input bit sel);
    int p;
    int m;
    p = sel ? 64 : 128;
    m = (n < 1) ? 1 : n;
    return p * m + ((a < m) ? a : m);
  endfunction

  task automatic set_cfg(input int a, input int n, input bit sel);
    @(negedge clk);
    swallow_a = 7'(a);
    main_n    = 11'(n);
    mod_sel   = sel;
  endtask

  task automatic wait_fp();
    do @(negedge clk); while (!fp_pulse);
  endtask

  // Called on an fp cycle; counts cycles to the next fp and mod_ctl highs.
  task automatic measure(output int per, output int hi, output int rises);
    bit prev;
    per = 0; hi = 0; rises = 0; prev = 1'b0;
    do begin
      if (mod_ctl) hi++;
      if (mod_ctl && !prev && per != 0) rises++;
      prev = mod_ctl;
      @(negedge clk);
      per++;
    end while (!fp_pulse);
  endtask

  task automatic apply_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(fp_pulse == 1'b0, "R9 fp in reset", fp_pulse, 0);
    chk(mod_ctl == 1'b0, "R9 mod_ctl in reset", mod_ctl, 0);
    chk(cfg_err == 1'b0, "R9 err in reset", cfg_err, 0);
    rst_n = 1'b1;
  endtask

  task automatic run_cfg(input int a, input int n, input bit sel, input string tag);
    int per;
    int hi;
    int rises;
    set_cfg(a, n, sel);
    wait_fp();
    measure(per, hi, rises);
    chk(per == exp_period(a, n, sel), tag, per, exp_period(a, n, sel));
    if (n >= 5 && a < n) begin
      chk(hi == a * ((sel ? 64 : 128) + 1), "R4 P+1 time", hi, a * ((sel ? 64 : 128) + 1));
      chk(rises == 0, "R4 single run", rises, 0);
    end
  endtask

  task automatic t_basic();
    run_cfg(3, 10, 1'b1, "R1 R2 P=64 period");
    run_cfg(3, 10, 1'b0, "R1 R2 P=128 period");
    run_cfg(17, 23, 1'b1, "R1 second pattern");
    chk(cfg_err == 1'b0, "R7 no err on legal", cfg_err, 0);
  endtask

  task automatic t_no_swallow();
    run_cfg(0, 5, 1'b0, "R4 A=0 N=5 period");
  endtask

  task automatic t_fp_width();
    int wide;
    wait_fp();
    @(negedge clk);
    wide = fp_pulse;
    chk(wide == 0, "R3 fp width", wide, 0);
  endtask

  task automatic t_max_swallow();
    run_cfg(127, 130, 1'b1, "R5 A=127 period");
  endtask

  task automatic t_midchange();
    int per;
    int hi;
    int rises;
    set_cfg(4, 12, 1'b1);
    wait_fp();
    wait_fp();
    per = 0;
    repeat (100) begin @(negedge clk); per++; end
    swallow_a = 7'd9; main_n = 11'd20; mod_sel = 1'b0;
    do begin @(negedge clk); per++; end while (!fp_pulse);
    chk(per == exp_period(4, 12, 1'b1), "R6 old period kept", per, exp_period(4, 12, 1'b1));
    measure(per, hi, rises);
    chk(per == exp_period(9, 20, 1'b0), "R6 new period", per, exp_period(9, 20, 1'b0));
  endtask

  task automatic t_illegal();
    int per;
    int hi;
    int rises;
    run_cfg(1, 3, 1'b1, "R8 N=3 period");
    chk(cfg_err == 1'b1, "R7 err on N<5", cfg_err, 1);
    run_cfg(6, 12, 1'b1, "R1 legal after err");
    chk(cfg_err == 1'b1, "R7 err sticky", cfg_err, 1);
    apply_reset();
    set_cfg(8, 6, 1'b1);
    wait_fp();
    chk(cfg_err == 1'b1, "R7 err on A>=N", cfg_err, 1);
    measure(per, hi, rises);
    chk(per == exp_period(8, 6, 1'b1), "R8 A>=N period", per, exp_period(8, 6, 1'b1));
    run_cfg(0, 0, 1'b1, "R8 N=0 period");
  endtask

  task automatic t_first_period();
    int per;
    swallow_a = 7'd2; main_n = 11'd7; mod_sel = 1'b1;
    apply_reset();
    per = 0;
    do begin @(negedge clk); per++; end while (!fp_pulse);
    chk(per == exp_period(2, 7, 1'b1) + 1, "R9 first period", per, exp_period(2, 7, 1'b1) + 1);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 200000 && !done) begin
      done = 1'b1;
      fails++;
      checks++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 200000);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    apply_reset();
    t_basic();
    t_no_swallow();
    t_fp_width();
    t_max_swallow();
    t_midchange();
    t_illegal();
    t_first_period();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule